// File: doc/BRIEF.md
# Stuck Bus Timeout and Recovery Clocking

This block guards the card side of a two-wire bus segment that sits behind a hot-swap buffer. Running on a system clock, it watches synchronized levels of the card-side data and clock lines. If at least one of them stays low for a programmable number of cycles, it raises a fault that tells the connection logic to separate the backplane from the card. After a guard interval it then pulls the card-side clock line low and releases it, in a bounded train of slow pulses. These pulses let a slave stuck in mid-byte finish shifting and release the data line.

The fault clears when both card lines are seen high at the same time, so the connection logic can re-qualify the bus. A rising edge on the enable input also clears it and forces a reconnect. While enable is low, no recovery clocking happens. Until the undervoltage lockout is released, the line levels are ignored. All intervals are parameters in system clock cycles. The block's defaults assume a 50 MHz clock: about 30 ms timeout, 40 us guard and 8.5 kHz pulses.

Top module: `stuck_bus_guard`

## Requirements
- R1: After reset, `fault_o` and `scl_pull_o` are both 0.
- R2: While `uv_ok_i` is 0, line levels are ignored. No fault is raised however long the lines stay low.
- R3: With `uv_ok_i` at 1, the stuck timer counts every cycle in which data, clock or both card lines are low. Which line is low may change from cycle to cycle. `fault_o` rises after exactly TIMEOUT_CYC such consecutive cycles.
- R4: A single cycle with both card lines high clears the stuck timer. A new timeout then needs a full TIMEOUT_CYC stuck cycles.
- R5: After `fault_o` rises, `scl_pull_o` stays 0 for GUARD_CYC cycles. The first pull-down starts on the cycle after that.
- R6: Each recovery pulse holds `scl_pull_o` at 1 for HALF_CYC cycles and then at 0 for HALF_CYC cycles. At most MAX_PULSES pulses are issued per fault. Once they are spent, `scl_pull_o` stays 0 and `fault_o` stays 1.
- R7: While `fault_o` is 1, a cycle with both card lines high clears `fault_o` and stops pulsing on the next cycle.
- R8: The pulse budget restarts at every newly declared fault. A fault that follows an episode cut short still gets the full MAX_PULSES.
- R9: While `en_lvl_i` is 0, no recovery pulse is driven. The timeout and the fault flag still operate.
- R10: An `en_rise_i` pulse during a fault clears `fault_o` on the next cycle. It also restarts the stuck timer from zero but leaves it running. A bus that stays stuck faults again TIMEOUT_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_sda_i | input | 1 | Synchronized card-side data line level |
| card_scl_i | input | 1 | Synchronized card-side clock line level |
| en_lvl_i | input | 1 | Enable level; 0 inhibits recovery clocking |
| en_rise_i | input | 1 | One-cycle pulse on a rising edge of enable |
| uv_ok_i | input | 1 | 1 once the undervoltage lockout has released |
| fault_o | output | 1 | Stuck fault and disconnect request |
| scl_pull_o | output | 1 | Request to pull the card-side clock line low |

## Verification
The timeout is tried in four patterns:
- a bus that is already stuck when the undervoltage lockout releases;
- data held low and then clock held low with no gap, which shows the timer counts "either line low" rather than one line;
- a single free cycle inside a long stuck stretch, which shows the timer restarts;
- an enable edge in mid-fault, which shows the timer restarts but stays armed.

Recovery is tried in three cases:
- a slave that lets go after three pulses, separating early stop from the pulse limit;
- a slave that never lets go, exercising the full budget and the quiet state after it, and showing the budget was reset;
- enable held low during a fault, which must yield no pulses at all.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GUARD,
    PH_LOW,
    PH_HIGH,
    PH_DONE
  } rec_phase_e;
endpackage

// File: rtl/stuck_timer.sv
module stuck_timer #(
  parameter int TIMEOUT_CYC = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt;

  assign expire = run && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || expire)  cnt <= '0;
    else if (run)            cnt <= cnt + 1'b1;
  end

  // R4
  free_clears_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/recovery_seq.sv
module recovery_seq
  import sbr_pkg::*;
#(
  parameter int GUARD_CYC  = 2000,
  parameter int HALF_CYC   = 2941,
  parameter int MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic bus_free,
  input  logic en_lvl,
  input  logic en_rise,
  output logic fault_o,
  output logic pull_o
);
  localparam int SPAN = (GUARD_CYC > HALF_CYC) ? GUARD_CYC : HALF_CYC;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int PW   = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYC - 1);
  localparam logic [CW-1:0] HALF_LAST  = CW'(HALF_CYC - 1);
  localparam logic [PW-1:0] PULSE_MAX  = PW'(MAX_PULSES);

  rec_phase_e    ph;
  logic [CW-1:0] tcnt;
  logic [PW-1:0] pcnt;

  assign fault_o = (ph != PH_IDLE);
  assign pull_o  = (ph == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      tcnt <= '0;
      pcnt <= '0;
    end else if (ph == PH_IDLE) begin
      if (expire) begin
        ph   <= PH_GUARD;
        tcnt <= '0;
        pcnt <= '0;
      end
    end else if (en_rise || bus_free) begin
      ph   <= PH_IDLE;
      tcnt <= '0;
    end else if (!en_lvl) begin
      if (ph != PH_DONE) begin
        ph   <= PH_GUARD;
        tcnt <= '0;
      end
    end else begin
      case (ph)
        PH_GUARD: begin
          if (tcnt == GUARD_LAST) begin
            ph   <= PH_LOW;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_LOW: begin
          if (tcnt == HALF_LAST) begin
            ph   <= PH_HIGH;
            tcnt <= '0;
            pcnt <= pcnt + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (tcnt == HALF_LAST) begin
            ph   <= (pcnt == PULSE_MAX) ? PH_DONE : PH_LOW;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: ph <= PH_DONE;
      endcase
    end
  end

  // R6
  pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PULSE_MAX);

  // R5
  low_entry_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_o) |-> ($past(ph) == PH_GUARD || $past(ph) == PH_HIGH));

  // R8
  fresh_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && expire) |=> (pcnt == '0));
endmodule

// File: rtl/stuck_bus_guard.sv
module stuck_bus_guard #(
  parameter int TIMEOUT_CYC = 1500000,
  parameter int GUARD_CYC   = 2000,
  parameter int HALF_CYC    = 2941,
  parameter int MAX_PULSES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_sda_i,
  input  logic card_scl_i,
  input  logic en_lvl_i,
  input  logic en_rise_i,
  input  logic uv_ok_i,
  output logic fault_o,
  output logic scl_pull_o
);
  logic bus_free;
  logic tmr_run;
  logic tmr_clr;
  logic tmr_expire;

  assign bus_free = card_sda_i && card_scl_i;
  assign tmr_run  = uv_ok_i && !bus_free && !fault_o;
  assign tmr_clr  = !uv_ok_i || bus_free || en_rise_i || fault_o;

  stuck_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .clr    (tmr_clr),
    .expire (tmr_expire)
  );

  recovery_seq #(
    .GUARD_CYC  (GUARD_CYC),
    .HALF_CYC   (HALF_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (tmr_expire),
    .bus_free (bus_free),
    .en_lvl   (en_lvl_i),
    .en_rise  (en_rise_i),
    .fault_o  (fault_o),
    .pull_o   (scl_pull_o)
  );

  // R3
  expire_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> fault_o);

  // R2
  lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_ok_i && !fault_o) |=> !fault_o);

  // R7
  free_ends_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && bus_free) |=> (!fault_o && !scl_pull_o));

  // R10
  edge_ends_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && en_rise_i) |=> !fault_o);

  // R9
  disabled_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lvl_i |=> !scl_pull_o);
endmodule

// File: tb/sim_stuck_bus_guard.sv
module sim_stuck_bus_guard;
  localparam int CLK_NS = 10;
  localparam int T = 40;
  localparam int G = 6;
  localparam int H = 4;
  localparam int M = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_hold = 1'b0;
  logic scl_hold = 1'b0;
  logic en_lvl = 1'b1;
  logic en_rise = 1'b0;
  logic uv_ok = 1'b0;
  logic fault, pull;
  wire  sda_w = ~sda_hold;
  wire  scl_w = ~(scl_hold | pull);

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int pulses_seen = 0;
  int release_after = 0;
  int run_len = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  stuck_bus_guard #(.TIMEOUT_CYC(T), .GUARD_CYC(G), .HALF_CYC(H), .MAX_PULSES(M)) u0 (
    .clk(clk), .rst_n(rst_n), .card_sda_i(sda_w), .card_scl_i(scl_w),
    .en_lvl_i(en_lvl), .en_rise_i(en_rise), .uv_ok_i(uv_ok),
    .fault_o(fault), .scl_pull_o(pull)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_pulses(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(H);
  endtask

  // monitor: measures each pull-down and compares it with the scoreboard
  always @(negedge clk) begin
    if (pull) run_len++;
    else if (run_len > 0) begin
      pulses_seen++;
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected pulse", run_len, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(run_len == e, "R6 pulse width", run_len, e);
      end
      run_len = 0;
      if (release_after != 0 && pulses_seen == release_after) begin
        sda_hold = 1'b0;
        scl_hold = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(!fault, "R1 fault after reset", fault, 0);
    check(!pull, "R1 pull after reset", pull, 0);

    // R2: stuck during lockout is ignored
    sda_hold = 1'b1;
    tick(3 * T);
    check(!fault, "R2 fault in lockout", fault, 0);

    // R3: already stuck at lockout release
    uv_ok = 1'b1;
    release_after = 3;
    push_pulses(3);
    tick(T - 1);
    check(!fault, "R3 fault one cycle early", fault, 0);
    tick(1);
    check(fault, "R3 fault at timeout", fault, 1);
    // R5: guard interval
    tick(G - 1);
    check(!pull, "R5 pull during guard", pull, 0);
    tick(1);
    check(pull, "R5 pull after guard", pull, 1);
    for (int i = 0; i < 200 && fault; i++) tick(1);
    check(!fault, "R7 fault after slave release", fault, 0);
    check(pulses_seen == 3, "R7 pulses before stop", pulses_seen, 3);
    pulses_seen = 0;
    release_after = 0;
    tick(2);

    // R4: one free cycle restarts the timer
    sda_hold = 1'b1;
    tick(T - 5);
    sda_hold = 1'b0;
    tick(1);
    sda_hold = 1'b1;
    push_pulses(M);
    tick(T - 1);
    check(!fault, "R4 no fault after restart", fault, 0);
    tick(1);
    check(fault, "R4 fault after full window", fault, 1);
    // R6 / R8: never released, full budget
    tick(G + 2 * H * M + 20);
    check(pulses_seen == M, "R8 full budget after short episode", pulses_seen, M);
    check(exp_q.size() == 0, "R6 pulses outstanding", exp_q.size(), 0);
    check(fault, "R6 fault held after budget", fault, 1);
    check(!pull, "R6 pull idle after budget", pull, 0);
    sda_hold = 1'b0;
    tick(1);
    check(!fault, "R7 fault cleared when free", fault, 0);
    pulses_seen = 0;
    tick(2);

    // R3: data low then clock low with no gap counts as one stretch
    sda_hold = 1'b1;
    tick(T / 2);
    sda_hold = 1'b0;
    scl_hold = 1'b1;
    tick(T / 2 - 1);
    check(!fault, "R3 mixed lines early", fault, 0);
    tick(1);
    check(fault, "R3 mixed lines timeout", fault, 1);

    // R9: enable low inhibits clocking
    en_lvl = 1'b0;
    tick(G + 4 * H + 10);
    check(pulses_seen == 0, "R9 pulses while disabled", pulses_seen, 0);
    check(fault, "R9 fault kept while disabled", fault, 1);

    // R10: enable edge clears fault, timer stays armed
    en_lvl = 1'b1;
    en_rise = 1'b1;
    tick(1);
    en_rise = 1'b0;
    check(!fault, "R10 fault after enable edge", fault, 0);
    tick(T - 1);
    check(!fault, "R10 early refault", fault, 0);
    tick(1);
    check(fault, "R10 refault after timeout", fault, 1);
    scl_hold = 1'b0;
    tick(1);
    check(!fault, "R7 fault cleared in guard", fault, 0);
    tick(2);
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule